// File: doc/BRIEF.md
# Pad Impedance Calibration Controller

This controller sets up and runs the automatic calibration of a memory interface's pad drive strength and on-die termination. It takes three targets in ohms, all held on configuration inputs: the address/command pad drive, the data-group pad drive (data, strobe, clock and mask pads), and the parallel termination. The two drive targets go to the pad logic as codes equal to the ohm value. For example, 60 ohms gives 0x3C and 40 ohms gives 0x28. The termination target is scaled by 1.6, so 75 ohms becomes 120 (0x78).

A start request latches the codes and sends a one-cycle start pulse to the analog calibration logic. The controller then stays busy for a fixed settle window of `SETTLE_CYC` clock cycles. There is no status handshake. At the end of the window it raises a sticky done flag. Calibration runs only for the DDR2 and DDR3 interface modes. In low-power DDR mode a start request completes at once and nothing is sent to the pads. A bypass input forces the termination code to zero and drops the termination calibration enable. Three calibration enables (termination, pull-down, pull-up) come up set after reset and can be rewritten.

Top module: `pad_cal_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and pad_start_o are 0, all three code outputs are 0, and pad_en_o is 3'b111.
- R2: A start_i accepted while idle with mem_mode_i = 0 (DDR2) or 1 (DDR3) drives pad_start_o high for exactly one cycle, in the cycle after start_i is sampled. busy_o rises in that same cycle.
- R3: busy_o stays high for exactly SETTLE_CYC cycles (300 by default). done_o becomes 1 in the cycle in which busy_o falls.
- R4: ac_code_o and dq_code_o equal ac_ohm_i and dq_ohm_i as sampled with the accepted start, for example 60 to 0x3C and 40 to 0x28.
- R5: odt_code_o is round-to-nearest(1.6 times odt_ohm_i), as sampled with the accepted start, saturated to 255. Examples: 75 to 120, 3 to 5, 2 to 3, 160 to 255.
- R6: When odt_bypass_i is 1 at the accepted start, odt_code_o is 0. While odt_bypass_i is 1, pad_en_o bit 2 (termination enable) is 0.
- R7: A start_i sampled while idle with mem_mode_i = 2 (low-power DDR) or 3 sets done_o in the next cycle. It produces no pad_start_o pulse, leaves busy_o low and leaves the codes unchanged.
- R8: start_i while busy_o is 1 is ignored: no pulse, no code change, and the running window ends on its original schedule.
- R9: done_o stays 1 until the next accepted calibration start, which clears it in the cycle after start_i is sampled.
- R10: en_we_i loads en_d_i into the enable register. Bit 2 is termination, bit 1 pull-down and bit 0 pull-up. pad_en_o shows the register, with bit 2 masked by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_mode_i | input | 2 | Interface mode: 0 DDR2, 1 DDR3, 2 low-power DDR, 3 reserved |
| ac_ohm_i | input | CODE_W | Address/command pad drive target in ohms |
| dq_ohm_i | input | CODE_W | Data-group pad drive target in ohms |
| odt_ohm_i | input | CODE_W | Termination target in ohms |
| odt_bypass_i | input | 1 | Bypass termination programming |
| start_i | input | 1 | Calibration start request |
| en_we_i | input | 1 | Enable register write strobe |
| en_d_i | input | N_EN | Enable register write data |
| pad_start_o | output | 1 | One-cycle start pulse to the pad calibration logic |
| pad_en_o | output | N_EN | Calibration enables to the pads |
| ac_code_o | output | CODE_W | Address/command drive code |
| dq_code_o | output | CODE_W | Data-group drive code |
| odt_code_o | output | CODE_W | Termination code |
| busy_o | output | 1 | Settle window running |
| done_o | output | 1 | Sticky calibration complete flag |

## Verification
The bench goes after the termination scaling at its rounding edges and at saturation. A truncating divider would give 4 for a 3-ohm target instead of 5. A missing clamp would wrap 160 ohms to 0. A second start is injected in the middle of a window. A design that restarts on it would show a second pad pulse and a window longer than 300 cycles. It would also latch the new codes. Low-power mode is checked for a finished flag with no pulse and no busy period, and a design that forgets the mode check would block for the whole window. Done is checked to be sticky across idle cycles and to be cleared by the next accepted start, together with the enable masking under bypass.

// File: rtl/pad_cal_pkg.sv
package pad_cal_pkg;
  typedef enum logic [1:0] {
    MODE_DDR2  = 2'd0,
    MODE_DDR3  = 2'd1,
    MODE_LPDDR = 2'd2,
    MODE_RSVD  = 2'd3
  } mem_mode_e;

  localparam int unsigned EN_PU   = 0;
  localparam int unsigned EN_PD   = 1;
  localparam int unsigned EN_TERM = 2;

  function automatic logic cal_mode_ok(input logic [1:0] mode);
    return (mode == MODE_DDR2) || (mode == MODE_DDR3);
  endfunction
endpackage

// File: rtl/pad_cal_conv.sv
// termination code = round(ohm * 8 / 5), clamped to field max
module pad_cal_conv #(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] ohm_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned PW   = CODE_W + 4;
  localparam int unsigned MAXV = (1 << CODE_W) - 1;

  logic [PW-1:0] num;
  logic [PW-1:0] quo;

  always_comb begin
    num = (PW'(ohm_i) << 3) + PW'(2);
    quo = num / PW'(5);
    if (quo > PW'(MAXV)) code_o = '1;
    else                 code_o = quo[CODE_W-1:0];
  end
endmodule

// File: rtl/pad_cal_timer.sv
module pad_cal_timer #(
  parameter int unsigned SETTLE_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic fin_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign fin_o  = (cnt_q == CW'(1));
endmodule

// File: rtl/pad_cal_enreg.sv
module pad_cal_enreg #(
  parameter int unsigned N_EN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [N_EN-1:0] d_i,
  output logic [N_EN-1:0] q_o
);
  for (genvar g = 0; g < N_EN; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[g] <= 1'b1;
      else if (we_i) q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/pad_cal_ctrl.sv
module pad_cal_ctrl #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_CYC = 300,
  parameter int unsigned N_EN       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mem_mode_i,
  input  logic [CODE_W-1:0] ac_ohm_i,
  input  logic [CODE_W-1:0] dq_ohm_i,
  input  logic [CODE_W-1:0] odt_ohm_i,
  input  logic              odt_bypass_i,
  input  logic              start_i,
  input  logic              en_we_i,
  input  logic [N_EN-1:0]   en_d_i,
  output logic              pad_start_o,
  output logic [N_EN-1:0]   pad_en_o,
  output logic [CODE_W-1:0] ac_code_o,
  output logic [CODE_W-1:0] dq_code_o,
  output logic [CODE_W-1:0] odt_code_o,
  output logic              busy_o,
  output logic              done_o
);
  import pad_cal_pkg::*;

  logic              busy, fin, accept, skip;
  logic [CODE_W-1:0] odt_conv;
  logic [N_EN-1:0]   en_q;

  assign accept = start_i && !busy &&  cal_mode_ok(mem_mode_i);
  assign skip   = start_i && !busy && !cal_mode_ok(mem_mode_i);

  pad_cal_conv #(.CODE_W(CODE_W)) u_conv (
    .ohm_i  (odt_ohm_i),
    .code_o (odt_conv)
  );

  pad_cal_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .busy_o (busy),
    .fin_o  (fin)
  );

  pad_cal_enreg #(.N_EN(N_EN)) u_enreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (en_we_i),
    .d_i    (en_d_i),
    .q_o    (en_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_code_o  <= '0;
      dq_code_o  <= '0;
      odt_code_o <= '0;
    end else if (accept) begin
      ac_code_o  <= ac_ohm_i;
      dq_code_o  <= dq_ohm_i;
      odt_code_o <= odt_bypass_i ? '0 : odt_conv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_start_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      pad_start_o <= accept;
      if (accept)           done_o <= 1'b0;
      else if (fin || skip) done_o <= 1'b1;
    end
  end

  always_comb begin
    pad_en_o = en_q;
    if (odt_bypass_i) pad_en_o[EN_TERM] = 1'b0;
  end

  assign busy_o = busy;
endmodule

// File: rtl/pad_cal_ctrl_chk.sv
module pad_cal_ctrl_chk #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_CYC = 300
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mem_mode_i,
  input logic              start_i,
  input logic              pad_start_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] ac_code_o,
  input logic [CODE_W-1:0] dq_code_o,
  input logic [CODE_W-1:0] odt_code_o
);
  localparam int unsigned WW = $clog2(SETTLE_CYC + 2) + 1;

  logic [WW-1:0] win_q;
  logic          mode_ok;

  assign mode_ok = (mem_mode_i == 2'd0) || (mem_mode_i == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (busy_o) win_q <= win_q + WW'(1);
    else             win_q <= '0;
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_start_o |=> !pad_start_o);

  a_r2_pulse_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> pad_start_o);

  a_r3_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (win_q == WW'(SETTLE_CYC)));

  a_r3_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_skip_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !mode_ok) |=> (done_o && !busy_o && !pad_start_o));

  a_r8_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(ac_code_o) && $stable(dq_code_o)
                             && $stable(odt_code_o) && !pad_start_o));

  a_r9_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_ok) |=> (!done_o && busy_o));

  a_r9_done_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
endmodule

bind pad_cal_ctrl pad_cal_ctrl_chk #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_mode_i  (mem_mode_i),
  .start_i     (start_i),
  .pad_start_o (pad_start_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ac_code_o   (ac_code_o),
  .dq_code_o   (dq_code_o),
  .odt_code_o  (odt_code_o)
);

// File: tb/pad_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module pad_cal_ctrl_tb_top;
  localparam int SETTLE = 300;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mem_mode_i = 2'd0;
  logic [7:0] ac_ohm_i = '0, dq_ohm_i = '0, odt_ohm_i = '0;
  logic       odt_bypass_i = 1'b0, start_i = 1'b0, en_we_i = 1'b0;
  logic [2:0] en_d_i = '0;
  logic       pad_start_o, busy_o, done_o;
  logic [2:0] pad_en_o;
  logic [7:0] ac_code_o, dq_code_o, odt_code_o;

  always #10 clk_i = ~clk_i;

  pad_cal_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_mode_i(mem_mode_i),
    .ac_ohm_i(ac_ohm_i), .dq_ohm_i(dq_ohm_i), .odt_ohm_i(odt_ohm_i),
    .odt_bypass_i(odt_bypass_i), .start_i(start_i), .en_we_i(en_we_i),
    .en_d_i(en_d_i), .pad_start_o(pad_start_o), .pad_en_o(pad_en_o),
    .ac_code_o(ac_code_o), .dq_code_o(dq_code_o), .odt_code_o(odt_code_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    logic [7:0] ac, dq, odt;
    int         busy_len;
    int         pulses;
    bit         cmp_codes;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] odt_model(input int ohm, input bit byp);
    int v;
    if (byp) return 8'd0;
    v = (ohm * 16 + 5) / 10;
    if (v > 255) v = 255;
    return 8'(v);
  endfunction

  // monitor: pops one expected item per rising edge of done
  int  mon_pulses = 0, mon_busy = 0;
  bit  done_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pad_start_o) mon_pulses++;
      if (busy_o)      mon_busy++;
      if (done_o && !done_prev) begin
        if (q.size() == 0) begin
          chk("R3 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " R3 busy length"}, mon_busy, e.busy_len);
          chk({e.tag, " R2 pulse count"}, mon_pulses, e.pulses);
          if (e.cmp_codes) begin
            chk({e.tag, " R4 ac code"},  ac_code_o,  e.ac);
            chk({e.tag, " R4 dq code"},  dq_code_o,  e.dq);
            chk({e.tag, " R5 odt code"}, odt_code_o, e.odt);
          end
        end
        mon_pulses = 0;
        mon_busy   = 0;
      end
      done_prev = done_o;
    end
  end

  task automatic drive_start(input logic [1:0] mode, input int ac, input int dq,
                             input int odt, input bit byp);
    @(negedge clk_i);
    mem_mode_i   = mode;
    ac_ohm_i     = 8'(ac);
    dq_ohm_i     = 8'(dq);
    odt_ohm_i    = 8'(odt);
    odt_bypass_i = byp;
    start_i      = 1'b1;
    @(negedge clk_i);
    start_i      = 1'b0;
  endtask

  task automatic run_cal(input string tag, input logic [1:0] mode, input int ac,
                         input int dq, input int odt, input bit byp);
    exp_t e;
    e.ac = 8'(ac); e.dq = 8'(dq); e.odt = odt_model(odt, byp);
    e.busy_len = SETTLE; e.pulses = 1; e.cmp_codes = 1'b1; e.tag = tag;
    q.push_back(e);
    drive_start(mode, ac, dq, odt, byp);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic write_en(input logic [2:0] v);
    @(negedge clk_i);
    en_d_i  = v;
    en_we_i = 1'b1;
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  task automatic main_seq();
    exp_t e;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 pad_start", pad_start_o, 0);
    chk("R1 ac code", ac_code_o, 0);
    chk("R1 dq code", dq_code_o, 0);
    chk("R1 odt code", odt_code_o, 0);
    chk("R1 enables", pad_en_o, 3'b111);

    // R7 low-power mode completes immediately
    e.ac = 0; e.dq = 0; e.odt = 0; e.busy_len = 0; e.pulses = 0;
    e.cmp_codes = 1'b0; e.tag = "lp";
    q.push_back(e);
    drive_start(2'd2, 60, 40, 75, 1'b0);
    chk("R7 done", done_o, 1);
    chk("R7 busy", busy_o, 0);
    chk("R7 pad_start", pad_start_o, 0);
    chk("R7 codes kept", {ac_code_o, dq_code_o, odt_code_o}, 0);
    wait_idle();
    drive_start(2'd3, 60, 40, 75, 1'b0);
    chk("R7 rsvd busy", busy_o, 0);
    chk("R7 rsvd pad_start", pad_start_o, 0);
    chk("R7 rsvd done", done_o, 1);

    // R2/R9 recommended settings in DDR3, plus ignored start (R8)
    run_cal("ddr3 rec", 2'd1, 60, 40, 75, 1'b0);
    chk("R2 pad_start high", pad_start_o, 1);
    chk("R2 busy high", busy_o, 1);
    chk("R9 done cleared", done_o, 0);
    @(negedge clk_i);
    chk("R2 pad_start one cycle", pad_start_o, 0);
    repeat (50) @(negedge clk_i);
    drive_start(2'd1, 1, 2, 3, 1'b0);
    chk("R8 no pulse", pad_start_o, 0);
    chk("R8 ac kept", ac_code_o, 8'h3C);
    chk("R8 dq kept", dq_code_o, 8'h28);
    chk("R8 odt kept", odt_code_o, 8'h78);
    wait_idle();

    // R9 done sticky
    repeat (20) @(negedge clk_i);
    chk("R9 done sticky", done_o, 1);

    // R5 rounding and saturation in DDR2
    foreach (e.tag[i]) ; // no-op keeps e in scope
    run_cal("r5 0",   2'd0, 10, 20, 0,   1'b0); wait_idle();
    run_cal("r5 1",   2'd0, 11, 21, 1,   1'b0); wait_idle();
    run_cal("r5 2",   2'd0, 12, 22, 2,   1'b0); wait_idle();
    run_cal("r5 3",   2'd0, 13, 23, 3,   1'b0); wait_idle();
    run_cal("r5 159", 2'd0, 14, 24, 159, 1'b0); wait_idle();
    run_cal("r5 160", 2'd0, 15, 25, 160, 1'b0); wait_idle();
    run_cal("r5 255", 2'd1, 255, 0, 255, 1'b0); wait_idle();

    // R6 bypass
    run_cal("r6 byp", 2'd1, 60, 40, 75, 1'b1);
    @(negedge clk_i);
    chk("R6 term enable masked", pad_en_o, 3'b011);
    wait_idle();
    chk("R6 odt code zero", odt_code_o, 0);
    @(negedge clk_i);
    odt_bypass_i = 1'b0;
    @(negedge clk_i);
    chk("R6 term enable back", pad_en_o, 3'b111);

    // R10 enable register
    write_en(3'b010);
    chk("R10 enables write", pad_en_o, 3'b010);
    write_en(3'b101);
    odt_bypass_i = 1'b1;
    @(negedge clk_i);
    chk("R10 enables with bypass", pad_en_o, 3'b001);
    odt_bypass_i = 1'b0;
    @(negedge clk_i);
    chk("R10 enables no bypass", pad_en_o, 3'b101);
    chk("R10 queue drained", q.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk_i);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule